// File: doc/BRIEF.md
# Reloading System Tick Timer

A periodic tick source built around a 24-bit down-counter. Software programs a reload value, clears the counter and sets the run bit. From then on the counter steps down by one on every qualified clock, stays at zero for one counting step and loads the reload value on the step after that. Each time the count steps from one to zero it sets a sticky count flag and, if the exception bit is set, raises a one-cycle request for system exception 15.

Counting is qualified by three conditions: the run bit, an external tick enable and the absence of a debug halt. When any of them is missing the counter holds its value. The register interface is a flat word bus with a two-bit register select. Writes take effect on the clock edge where they are presented. Reads return data in the same cycle.

Top module: `systick_timer`

## Requirements
- R1: After reset, all three registers read zero and `irqReq` is low.
- R2: The select `addr` maps 0 to control/status, 1 to the reload value and 2 to the current count. Select 3 reads zero. In control/status, bit 0 is the run bit and bit 1 is the exception enable; both are read/write. Bit 16 is the count flag, which is read-only. Only bits [23:0] of the reload and current registers hold data. Every bit that holds no data reads zero.
- R3: While counting is qualified, a count of zero loads the reload value on the next clock edge, and a nonzero count decreases by exactly one per edge.
- R4: The count flag is set on the edge where the count steps from 1 to 0. It is cleared by a read of control/status. If the set and the read-clear fall on the same edge, the flag ends up set.
- R5: `irqReq` is high for exactly the one cycle after a 1-to-0 step, and only when the exception enable was set at that step.
- R6: While `debugHalt` is high the count does not change, except for a write to the current register.
- R7: While `tickEn` is low the count does not change, except for a write to the current register.
- R8: While the run bit is clear the count holds its value.
- R9: Any write to the current register sets the count to zero, whatever the write data. The same write also clears the count flag.
- R10: With a reload value of zero, a counter at zero stays at zero. In that case the flag is never set and `irqReq` never goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a read of control/status clears the flag) |
| addr | input | 2 | Register select |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the same cycle as the read strobe |
| tickEn | input | 1 | Count qualifier; counting happens only while it is high |
| debugHalt | input | 1 | Freezes the counter while high |
| irqReq | output | 1 | One-cycle request for tick exception 15 |

## Verification
A write is registered on the edge where it is presented. Read data is combinational and shows the state before that edge, so the bench samples it 1 ns after a falling edge. The counter does not move on the edge that sets the run bit. Its first load happens on the following edge, and each further counting edge gives one new value. As a result, back-to-back reads of the current register, one per cycle, step through the expected sequence. The flag and `irqReq` belong to the cycle after the 1-to-0 edge, which is the cycle where the current register reads zero; the bench checks `irqReq` in that cycle and again one cycle later. The freeze tests set the qualifier on a falling edge, compare reads taken across several edges, and then show a decrement after release.

// File: rtl/systick_pkg.sv
package systick_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_SPARE   = 2'd3
  } tick_sel_e;

  localparam int RUN_BIT  = 0;
  localparam int IRQ_BIT  = 1;
  localparam int FLAG_BIT = 16;

  typedef struct packed {
    logic advance;
    logic clear;
  } tick_strobe_t;

endpackage

// File: rtl/systick_datapath.sv
module systick_datapath
  import systick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tick_strobe_t     strobe,
  input  logic [CNT_W-1:0] reloadValue,
  output logic [CNT_W-1:0] curValue,
  output logic             zeroHit
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             atZero;
  logic [CNT_W-1:0] nextValue;

  always_comb begin
    atZero    = (curValue == ZERO);
    nextValue = atZero ? reloadValue : (curValue - ONE);
    zeroHit   = strobe.advance && !strobe.clear && (curValue == ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curValue <= ZERO;
    end else if (strobe.clear) begin
      curValue <= ZERO;
    end else if (strobe.advance) begin
      curValue <= nextValue;
    end
  end

endmodule

// File: rtl/systick_ctrl.sv
module systick_ctrl
  import systick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  input  logic              debugHalt,
  input  logic [CNT_W-1:0]  curValue,
  input  logic              zeroHit,
  output tick_strobe_t      strobe,
  output logic [CNT_W-1:0]  reloadValue,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq,
  output logic              runEn,
  output logic              countFlag
);

  tick_sel_e sel;
  logic      irqEn;
  logic      writeCtrl;
  logic      writeReload;
  logic      writeCurrent;
  logic      readCtrl;
  logic      unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:CNT_W];

  always_comb begin
    sel            = tick_sel_e'(addr);
    writeCtrl      = wrEn && (sel == SEL_CTRL);
    writeReload    = wrEn && (sel == SEL_RELOAD);
    writeCurrent   = wrEn && (sel == SEL_CURRENT);
    readCtrl       = rdEn && (sel == SEL_CTRL);
    strobe.advance = runEn && tickEn && !debugHalt;
    strobe.clear   = writeCurrent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn       <= 1'b0;
      irqEn       <= 1'b0;
      reloadValue <= '0;
    end else begin
      if (writeCtrl) begin
        runEn <= wrData[RUN_BIT];
        irqEn <= wrData[IRQ_BIT];
      end
      if (writeReload) begin
        reloadValue <= wrData[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countFlag <= 1'b0;
    end else if (zeroHit) begin
      countFlag <= 1'b1;
    end else if (readCtrl || writeCurrent) begin
      countFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq <= 1'b0;
    end else begin
      irqReq <= zeroHit && irqEn;
    end
  end

  always_comb begin
    rdData = '0;
    case (sel)
      SEL_CTRL: begin
        rdData[RUN_BIT]  = runEn;
        rdData[IRQ_BIT]  = irqEn;
        rdData[FLAG_BIT] = countFlag;
      end
      SEL_RELOAD:  rdData[CNT_W-1:0] = reloadValue;
      SEL_CURRENT: rdData[CNT_W-1:0] = curValue;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickEn,
  input  logic              debugHalt,
  output logic              irqReq
);

  tick_strobe_t     strobe;
  logic [CNT_W-1:0] curValue;
  logic [CNT_W-1:0] reloadValue;
  logic             zeroHit;
  logic             runEn;
  logic             countFlag;

  systick_ctrl #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .addr       (addr),
    .wrData     (wrData),
    .tickEn     (tickEn),
    .debugHalt  (debugHalt),
    .curValue   (curValue),
    .zeroHit    (zeroHit),
    .strobe     (strobe),
    .reloadValue(reloadValue),
    .rdData     (rdData),
    .irqReq     (irqReq),
    .runEn      (runEn),
    .countFlag  (countFlag)
  );

  systick_datapath #(
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reloadValue(reloadValue),
    .curValue   (curValue),
    .zeroHit    (zeroHit)
  );

endmodule

// File: rtl/systick_timer_chk.sv
module systick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic              tickEn,
  input logic              debugHalt,
  input logic [DATA_W-1:0] rdData,
  input logic              irqReq,
  input logic [CNT_W-1:0]  curVal,
  input logic [CNT_W-1:0]  reloadVal,
  input logic              runEn,
  input logic              countFlag
);

  logic curWrite;
  logic reloadWrite;
  assign curWrite    = wrEn && (addr == 2'd2);
  assign reloadWrite = wrEn && (addr == 2'd1);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:CNT_W] == '0); // R2

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tickEn && !debugHalt && curVal != '0 && !curWrite)
      |=> (curVal == $past(curVal) - CNT_W'(1))); // R3

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (countFlag && curVal == '0)); // R4

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq); // R5

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (debugHalt && !curWrite) |=> $stable(curVal)); // R6

  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !curWrite) |=> $stable(curVal)); // R7

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !curWrite) |=> $stable(curVal)); // R8

  AST_CUR_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    curWrite |=> (curVal == '0 && !countFlag)); // R9

  AST_ZERO_RELOAD_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (curVal == '0 && reloadVal == '0 && !reloadWrite) |=> (curVal == '0 && !irqReq)); // R10

endmodule

bind systick_timer systick_timer_chk #(
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .tickEn   (tickEn),
  .debugHalt(debugHalt),
  .rdData   (rdData),
  .irqReq   (irqReq),
  .curVal   (curValue),
  .reloadVal(reloadValue),
  .runEn    (runEn),
  .countFlag(countFlag)
);

// File: tb/systick_timer_tb.sv
module systick_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RLD  = 2'd1;
  localparam logic [1:0] A_CUR  = 2'd2;
  localparam logic [1:0] A_SPR  = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tickEn = 1'b1;
  logic        debugHalt = 1'b0;
  logic        irqReq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  systick_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickEn(tickEn),
    .debugHalt(debugHalt), .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    rdEn = 1'b0; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
    wrEn = 1'b0; rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    read_reg(a, v);
    check(req, v, exp);
  endtask

  task automatic test_reset();
    expect_reg("R1 ctrl", A_CTRL, 32'h0);
    expect_reg("R1 reload", A_RLD, 32'h0);
    expect_reg("R1 current", A_CUR, 32'h0);
    check("R1 irq", {31'd0, irqReq}, 32'h0);
  endtask

  task automatic test_wrap_irq();
    write_reg(A_RLD, 32'd5);
    write_reg(A_CUR, 32'd0);
    write_reg(A_CTRL, 32'h3);
    expect_reg("R3 first", A_CUR, 32'd0);
    expect_reg("R3 load", A_CUR, 32'd5);
    for (int k = 4; k >= 1; k--) expect_reg("R3 step", A_CUR, 32'(k));
    check("R5 irq high", {31'd0, irqReq}, 32'h1);
    expect_reg("R3 zero", A_CUR, 32'd0);
    check("R5 irq one cycle", {31'd0, irqReq}, 32'h0);
    expect_reg("R4 flag set", A_CTRL, 32'h0001_0003);
    expect_reg("R4 flag cleared", A_CTRL, 32'h0000_0003);
    write_reg(A_CTRL, 32'h0);
  endtask

  task automatic test_no_irq_set_wins();
    write_reg(A_CUR, 32'd0);
    write_reg(A_RLD, 32'd2);
    write_reg(A_CTRL, 32'h1);
    expect_reg("R3 first", A_CUR, 32'd0);
    expect_reg("R3 load", A_CUR, 32'd2);
    expect_reg("R4 read at one", A_CTRL, 32'h0000_0001);
    check("R5 irq masked", {31'd0, irqReq}, 32'h0);
    expect_reg("R4 set wins", A_CTRL, 32'h0001_0001);
    expect_reg("R4 cleared", A_CTRL, 32'h0000_0001);
    write_reg(A_CTRL, 32'h0);
  endtask

  task automatic test_halt_and_stop();
    write_reg(A_CUR, 32'd0);
    write_reg(A_RLD, 32'd100);
    write_reg(A_CTRL, 32'h1);
    expect_reg("R3 first", A_CUR, 32'd0);
    expect_reg("R3 load", A_CUR, 32'd100);
    expect_reg("R3 dec", A_CUR, 32'd99);
    debugHalt = 1'b1;
    expect_reg("R6 halt a", A_CUR, 32'd98);
    expect_reg("R6 halt b", A_CUR, 32'd98);
    expect_reg("R6 halt c", A_CUR, 32'd98);
    debugHalt = 1'b0;
    expect_reg("R6 release", A_CUR, 32'd98);
    expect_reg("R6 resumes", A_CUR, 32'd97);
    write_reg(A_CTRL, 32'h0);
    expect_reg("R8 stopped a", A_CUR, 32'd95);
    expect_reg("R8 stopped b", A_CUR, 32'd95);
  endtask

  task automatic test_tick_gate();
    write_reg(A_CUR, 32'd0);
    write_reg(A_RLD, 32'd50);
    write_reg(A_CTRL, 32'h1);
    expect_reg("R3 first", A_CUR, 32'd0);
    expect_reg("R3 load", A_CUR, 32'd50);
    tickEn = 1'b0;
    expect_reg("R7 gated a", A_CUR, 32'd49);
    expect_reg("R7 gated b", A_CUR, 32'd49);
    tickEn = 1'b1;
    expect_reg("R7 open", A_CUR, 32'd49);
    expect_reg("R7 counts", A_CUR, 32'd48);
    write_reg(A_CTRL, 32'h0);
  endtask

  task automatic test_cur_write();
    write_reg(A_CUR, 32'd0);
    write_reg(A_RLD, 32'd3);
    write_reg(A_CTRL, 32'h1);
    expect_reg("R3 first", A_CUR, 32'd0);
    for (int k = 3; k >= 0; k--) expect_reg("R3 run", A_CUR, 32'(k));
    write_reg(A_CUR, 32'h00AB_CDEF);
    expect_reg("R9 cleared", A_CUR, 32'd0);
    expect_reg("R9 flag cleared", A_CTRL, 32'h0000_0001);
    write_reg(A_CTRL, 32'h0);
  endtask

  task automatic test_zero_reload();
    write_reg(A_RLD, 32'd0);
    write_reg(A_CUR, 32'd0);
    write_reg(A_CTRL, 32'h3);
    for (int k = 0; k < 4; k++) begin
      expect_reg("R10 stays zero", A_CUR, 32'd0);
      check("R10 no irq", {31'd0, irqReq}, 32'h0);
    end
    expect_reg("R10 no flag", A_CTRL, 32'h0000_0003);
    write_reg(A_CTRL, 32'h0);
  endtask

  task automatic test_fields();
    write_reg(A_RLD, 32'hFFFF_FFFF);
    expect_reg("R2 reload width", A_RLD, 32'h00FF_FFFF);
    write_reg(A_CUR, 32'hFFFF_FFFF);
    expect_reg("R2 current", A_CUR, 32'h0);
    write_reg(A_CTRL, 32'hFFFF_FFFF);
    expect_reg("R2 ctrl bits", A_CTRL, 32'h0000_0003);
    write_reg(A_CTRL, 32'h0);
    expect_reg("R2 spare", A_SPR, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_wrap_irq();
    test_no_irq_set_wins();
    test_halt_and_stop();
    test_tick_gate();
    test_cur_write();
    test_zero_reload();
    test_fields();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule